// File: doc/BRIEF.md
# Power-Up Reset Hold and Bus Phase Generator

This block sits between the power supervision logic and the bus clocking of a chip. A power-on or low-voltage event holds the chip in reset. Once the event input falls, the block waits a fixed number of reference-oscillator cycles. For that whole wait it drives an active-low reset output and keeps both bus phase enables idle. When the wait ends, reset is released and a status flag goes high. From then on the block produces two bus phase enables at one quarter of the selected clock source rate.

The design clock runs at the oscillator rate. The faster source is presented as a one-cycle enable strobe sampled in the same domain. A select input chooses which source advances the divide-by-four counter. A change of that select is applied only when a four-tick bus period completes, so no bus period is ever cut short.

Top module: `busclk_reset_seq`

## Requirements
- R1: While `rst` or `pwr_evt` is high, `rst_n_out` and `ready` are low from the next clock edge onward.
- R2: After `pwr_evt` falls, `rst_n_out` stays low for exactly 4096 clock edges and goes high right after the 4096th edge.
- R3: A new `pwr_evt` pulse while the wait is running restarts the 4096-edge count from zero.
- R4: `bus_ph1` and `bus_ph2` are both low whenever `rst_n_out` is low.
- R5: With `src_sel` = 0 (oscillator source), every clock cycle is a source tick. After release, `bus_ph1` is high on the first cycle, and then on every fourth cycle. `bus_ph2` is high on the cycles two ticks after each `bus_ph1`.
- R6: With `src_sel` = 1 (PLL source), the divider advances only on cycles where `pll_tick` is high. `bus_ph1` is high on tick 0 of each group of four ticks and `bus_ph2` on tick 2. Both phase enables are low on every cycle without a tick.
- R7: A change of `src_sel` after release takes effect only on the tick that follows the fourth tick of the current bus period.
- R8: `bus_ph1` and `bus_ph2` are never high in the same cycle.
- R9: `ready` goes high in the same cycle as `rst_n_out` and stays high until the next reset event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock at the oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_evt | input | 1 | Power-on or low-voltage reset event, active high |
| src_sel | input | 1 | Bus clock source: 0 oscillator, 1 PLL |
| pll_tick | input | 1 | One-cycle strobe at the PLL source rate |
| rst_n_out | output | 1 | Active-low reset output to the chip |
| bus_ph1 | output | 1 | First bus phase enable |
| bus_ph2 | output | 1 | Second bus phase enable |
| ready | output | 1 | High once reset is released, until the next event |

## Verification
The checker watches several properties on every cycle. It confirms that an event pulls reset and the status flag low, and that the phase enables stay idle while reset is low. It confirms that the two phases never overlap and that the status flag does not drop without an event. It also counts the cycles since the event fell and checks that reset rises exactly at the timeout. Other properties depend on the internal state of the divider, which the ports do not expose, so only the directed scenarios can show them. These are the ordering of the phases under both sources, the restart of the count when an event arrives in mid-wait, and the one-period delay before a change of source is applied.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    localparam int unsigned DEF_TIMEOUT = 4096;
    localparam int unsigned DEF_DIV     = 4;

    typedef enum logic [0:0] {
        SRC_OSC = 1'b0,
        SRC_PLL = 1'b1
    } src_e;

    typedef struct packed {
        logic ph1;
        logic ph2;
    } bus_phase_t;

    // A phase enable fires only on a source tick at its slot in the period.
    function automatic bus_phase_t decode_phase(input logic tick,
                                                input logic at_first,
                                                input logic at_mid);
        bus_phase_t p;
        p.ph1 = tick & at_first;
        p.ph2 = tick & at_mid;
        return p;
    endfunction

endpackage

// File: rtl/busclk_por_timer.sv
module busclk_por_timer #(
    parameter int unsigned TIMEOUT = busclk_pkg::DEF_TIMEOUT
) (
    input  logic clk,
    input  logic hold,
    output logic done
);
    localparam int unsigned CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (hold) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/busclk_src_sel.sv
module busclk_src_sel (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic src_sel,
    input  logic pll_tick,
    input  logic at_wrap,
    output logic tick
);
    import busclk_pkg::*;

    src_e sel_q;

    // Before release the select is followed freely; after release it is
    // taken only on the tick that closes a bus period.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SRC_OSC;
        end else if (!run || (tick && at_wrap)) begin
            sel_q <= src_e'(src_sel);
        end
    end

    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (sel_q == SRC_PLL) begin
            tick = pll_tick;
        end else begin
            tick = 1'b1;
        end
    end
endmodule

// File: rtl/busclk_div.sv
module busclk_div #(
    parameter int unsigned DIV = busclk_pkg::DEF_DIV
) (
    input  logic                   clk,
    input  logic                   run,
    input  logic                   tick,
    output logic                   at_wrap,
    output busclk_pkg::bus_phase_t phase
);
    import busclk_pkg::*;

    localparam int unsigned DW  = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);
    localparam logic [DW-1:0] MID  = DW'(DIV / 2);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign at_wrap = (cnt_q == LAST);
    assign phase   = decode_phase(tick, cnt_q == '0, cnt_q == MID);
endmodule

// File: rtl/busclk_reset_seq.sv
module busclk_reset_seq #(
    parameter int unsigned TIMEOUT = busclk_pkg::DEF_TIMEOUT,
    parameter int unsigned DIV     = busclk_pkg::DEF_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_evt,
    input  logic src_sel,
    input  logic pll_tick,
    output logic rst_n_out,
    output logic bus_ph1,
    output logic bus_ph2,
    output logic ready
);
    import busclk_pkg::*;

    logic       running;
    logic       tick;
    logic       at_wrap;
    bus_phase_t phase;

    busclk_por_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk  (clk),
        .hold (rst | pwr_evt),
        .done (running)
    );

    busclk_src_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .src_sel  (src_sel),
        .pll_tick (pll_tick),
        .at_wrap  (at_wrap),
        .tick     (tick)
    );

    busclk_div #(.DIV(DIV)) u_div (
        .clk     (clk),
        .run     (running),
        .tick    (tick),
        .at_wrap (at_wrap),
        .phase   (phase)
    );

    assign rst_n_out = running;
    assign ready     = running;
    assign bus_ph1   = phase.ph1;
    assign bus_ph2   = phase.ph2;
endmodule

// File: rtl/busclk_reset_seq_chk.sv
module busclk_reset_seq_chk #(
    parameter int unsigned TIMEOUT = busclk_pkg::DEF_TIMEOUT
) (
    input logic clk,
    input logic rst,
    input logic pwr_evt,
    input logic rst_n_out,
    input logic bus_ph1,
    input logic bus_ph2,
    input logic ready
);
    int unsigned held_cyc;

    always_ff @(posedge clk) begin
        if (rst || pwr_evt) begin
            held_cyc <= 0;
        end else if (!rst_n_out && held_cyc < TIMEOUT + 1) begin
            held_cyc <= held_cyc + 1;
        end
    end

    a_r1_event_holds: assert property (@(posedge clk) disable iff (rst)
        pwr_evt |=> (!rst_n_out && !ready));

    a_r2_exact_timeout: assert property (@(posedge clk) disable iff (rst || pwr_evt)
        $rose(rst_n_out) |-> (held_cyc == TIMEOUT));

    a_r4_idle_in_reset: assert property (@(posedge clk) disable iff (rst)
        !rst_n_out |-> (!bus_ph1 && !bus_ph2));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(bus_ph1 && bus_ph2));

    a_r9_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        (ready && !pwr_evt) |=> ready);
endmodule

bind busclk_reset_seq busclk_reset_seq_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_evt   (pwr_evt),
    .rst_n_out (rst_n_out),
    .bus_ph1   (bus_ph1),
    .bus_ph2   (bus_ph2),
    .ready     (ready)
);

// File: tb/busclk_reset_seq_tb.sv
module busclk_reset_seq_tb;
    localparam int TO = 4096;

    logic clk = 1'b0;
    logic rst, pwr_evt, src_sel, pll_tick;
    logic rst_n_out, bus_ph1, bus_ph2, ready;
    int   n_chk = 0;
    int   n_err = 0;

    always #10 clk = ~clk;

    busclk_reset_seq u_dut (
        .clk(clk), .rst(rst), .pwr_evt(pwr_evt), .src_sel(src_sel),
        .pll_tick(pll_tick), .rst_n_out(rst_n_out), .bus_ph1(bus_ph1),
        .bus_ph2(bus_ph2), .ready(ready)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Event pulse, optional restart in mid-wait (R3), then the exact timeout (R2).
    task automatic release_seq(input bit restart);
        @(negedge clk); pwr_evt = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "rst_n_out under event", rst_n_out, 1'b0);
        chk("R1", "ready under event", ready, 1'b0);
        chk("R4", "ph1 under event", bus_ph1, 1'b0);
        pwr_evt = 1'b0;
        if (restart) begin
            repeat (2000) @(posedge clk);
            @(negedge clk); pwr_evt = 1'b1;
            @(posedge clk);
            @(negedge clk); pwr_evt = 1'b0;
            repeat (2500) @(posedge clk);
            @(negedge clk);
            chk("R3", "still held after restart", rst_n_out, 1'b0);
            repeat (TO - 2501) @(posedge clk);
        end else begin
            repeat (TO - 1) @(posedge clk);
        end
        @(negedge clk);
        chk("R2", "low at edge TO-1", rst_n_out, 1'b0);
        chk("R4", "ph1 idle at edge TO-1", bus_ph1, 1'b0);
        chk("R4", "ph2 idle at edge TO-1", bus_ph2, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R2", "released at edge TO", rst_n_out, 1'b1);
        chk("R9", "ready with release", ready, 1'b1);
    endtask

    // mode 0: no pll ticks, 1: pll tick every third cycle
    task automatic run_bus(input string req, input int n, input int sw_at,
                           input logic sw_val, input int mode);
        int   m = 0;
        logic sel_m = src_sel;
        for (int i = 0; i < n; i++) begin
            logic t;
            if (i == sw_at) src_sel = sw_val;
            pll_tick = (mode == 1) ? (i % 3 == 0) : 1'b0;
            #1;
            t = sel_m ? pll_tick : 1'b1;
            chk(req, $sformatf("ph1 cycle %0d", i), bus_ph1, t && (m == 0));
            chk(req, $sformatf("ph2 cycle %0d", i), bus_ph2, t && (m == 2));
            chk("R8", "no overlap", bus_ph1 && bus_ph2, 1'b0);
            chk("R9", "ready held", ready, 1'b1);
            if (t) begin
                if (m == 3) begin m = 0; sel_m = src_sel; end
                else m++;
            end
            @(negedge clk);
        end
        pll_tick = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; pwr_evt = 1'b1; src_sel = 1'b0; pll_tick = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "rst_n_out in reset", rst_n_out, 1'b0);
        chk("R1", "ready in reset", ready, 1'b0);
        chk("R4", "ph1 in reset", bus_ph1, 1'b0);
        chk("R4", "ph2 in reset", bus_ph2, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_reevent();
        pwr_evt = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9", "ready drops on event", ready, 1'b0);
        chk("R1", "reset reasserted", rst_n_out, 1'b0);
        chk("R4", "ph1 idle after event", bus_ph1, 1'b0);
        chk("R4", "ph2 idle after event", bus_ph2, 1'b0);
        pwr_evt = 1'b0;
    endtask

    initial begin
        t_reset();
        src_sel = 1'b0;
        release_seq(1'b0);
        run_bus("R5", 12, -1, 1'b0, 0);
        t_reevent();
        src_sel = 1'b1;
        release_seq(1'b1);
        run_bus("R6", 18, -1, 1'b1, 1);
        src_sel = 1'b0;
        release_seq(1'b0);
        run_bus("R7", 24, 5, 1'b1, 1);
        src_sel = 1'b1;
        release_seq(1'b0);
        run_bus("R7", 24, 4, 1'b0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule